// File: doc/BRIEF.md
# Delayed Transaction Target Controller

This block is the target side of a slow bridge on a parallel shared bus. When an initiator starts an eligible read or write, the controller does not try to serve it at once. It captures the command, address, byte enables and write data into a single slot and answers with a retry. It then carries out the access on a simple request/acknowledge port on the slow side. When the slow side returns, the read data or write status is held until the initiator comes back with exactly the same request. That matching repeat receives the completion, and the slot is then freed.

While the slot is occupied, every other eligible request is retried and nothing about it is stored. A completion that is never collected is dropped after a long timeout, so a vanished initiator cannot hold the slot forever.

The bus is presented at transaction level. `addr_valid` marks the address phase, and the command, address, byte enables and write data are valid alongside it. In the cycle after the address phase, the controller drives its first-data-phase answer on `devsel`, `trdy` and `stop` (all active-high) for one cycle, with `rdata`.

The controller is a three-state machine:
- `S_IDLE`: the slot is free.
- `S_ISSUE`: the slow-side request is outstanding.
- `S_READY`: the completion is held and the discard timer is running.

Its transitions are:
- Capture: `S_IDLE` to `S_ISSUE`, on an eligible request.
- Acknowledge: `S_ISSUE` to `S_READY`, on `sec_ack`.
- Deliver: `S_READY` to `S_IDLE`, on a matching repeat.
- Discard: `S_READY` to `S_IDLE`, when the timer expires.

Top module: `dly_txn_target`

## Requirements
- R1: After reset, `devsel`, `trdy`, `stop` and `sec_req` are low.
- R2: The eligible 4-bit command codes are 0000, 0010, 0011, 0110, 1010, 1011, 1100 and 1110. The other eight codes get no answer (`devsel`, `trdy` and `stop` stay low) and start no slow-side access.
- R3: An eligible request that finds the slot free is answered with a retry (`devsel`=1, `stop`=1, `trdy`=0) in the cycle after `addr_valid`. From the next cycle on, `sec_req` is high with the captured address, byte enables, write data and command.
- R4: `sec_req` and its address stay steady until `sec_ack`. `sec_write` is 1 exactly for codes 0011 and 1011.
- R5: While the slot is busy, a non-matching eligible request is retried and is not latched. The stored request and its result are unchanged.
- R6: A matching repeat that arrives while the slow-side access is still outstanding is retried, and the access continues undisturbed.
- R7: A matching repeat after the completion is ready gets `devsel`=1, `trdy`=1, `stop`=1. Its `rdata` is the slow-side data for reads and 0 for writes. The slot is then free.
- R8: A repeat matches only if its command, address and byte enables are equal to the stored ones. For write commands, its write data must be equal as well.
- R9: A completion not collected within `DISCARD_CYCLES` (default 32768) cycles of becoming ready is dropped. A later identical request is then treated as new: it is retried and starts a fresh slow-side access.
- R10: Every answer lasts exactly one cycle and appears only in the cycle after an address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_valid | input | 1 | Address phase strobe |
| cmd | input | 4 | Bus command code |
| addr | input | ADDR_W | Request address |
| be | input | BE_W | Byte enables, active-high |
| wdata | input | DATA_W | Write data of the request |
| devsel | output | 1 | Target claims the transaction |
| trdy | output | 1 | Data transferred in this phase |
| stop | output | 1 | Target ends the transaction |
| rdata | output | DATA_W | Read data with a completion |
| sec_req | output | 1 | Slow-side access request |
| sec_write | output | 1 | Slow-side access is a write |
| sec_addr | output | ADDR_W | Slow-side address |
| sec_be | output | BE_W | Slow-side byte enables |
| sec_wdata | output | DATA_W | Slow-side write data |
| sec_ack | input | 1 | Slow-side access done |
| sec_rdata | input | DATA_W | Slow-side read data |

## Verification
All sixteen command codes are swept through a full capture, access and collection cycle. This separates the eligible set from the ignored set and separates reads from writes by `sec_write` and `rdata`.

Repeats are then sent that differ from the stored request in one field only: address, byte enables or write data. These tell a true match from a near miss. Each is sent both while the access is outstanding and once the completion is ready, which separates the pending-retry path from the delivery path.

Two collections placed just inside and just outside the discard window pin down the timeout. Only the late one must restart a slow-side access.

// File: rtl/dly_txn_pkg.sv
package dly_txn_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_READY = 2'd2
    } slot_state_e;

    // Commands handled through the delayed path
    function automatic logic cmd_eligible(input logic [3:0] c);
        unique case (c)
            4'b0000, 4'b0010, 4'b0011, 4'b0110,
            4'b1010, 4'b1011, 4'b1100, 4'b1110: return 1'b1;
            default:                            return 1'b0;
        endcase
    endfunction

    function automatic logic cmd_is_write(input logic [3:0] c);
        return (c == 4'b0011) || (c == 4'b1011);
    endfunction

endpackage

// File: rtl/dly_txn_slot.sv
module dly_txn_slot #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [3:0]        in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              cap,
    input  logic [DATA_W-1:0] cap_data,
    output logic [3:0]        q_cmd,
    output logic [ADDR_W-1:0] q_addr,
    output logic [BE_W-1:0]   q_be,
    output logic [DATA_W-1:0] q_wdata,
    output logic [DATA_W-1:0] q_result,
    output logic              match
);
    import dly_txn_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_cmd    <= '0;
            q_addr   <= '0;
            q_be     <= '0;
            q_wdata  <= '0;
            q_result <= '0;
        end else begin
            if (load) begin
                q_cmd   <= in_cmd;
                q_addr  <= in_addr;
                q_be    <= in_be;
                q_wdata <= in_wdata;
            end
            if (cap) begin
                q_result <= cmd_is_write(q_cmd) ? '0 : cap_data;
            end
        end
    end

    // Write data takes part in the compare only for write commands
    always_comb begin
        match = (in_cmd == q_cmd) && (in_addr == q_addr) && (in_be == q_be)
                && (!cmd_is_write(q_cmd) || (in_wdata == q_wdata));
    end

endmodule

// File: rtl/dly_txn_discard_tmr.sv
module dly_txn_discard_tmr #(
    parameter int LIMIT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/dly_txn_target.sv
module dly_txn_target #(
    parameter int ADDR_W         = 32,
    parameter int DATA_W         = 32,
    parameter int BE_W           = DATA_W / 8,
    parameter int DISCARD_CYCLES = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic              devsel,
    output logic              trdy,
    output logic              stop,
    output logic [DATA_W-1:0] rdata,
    output logic              sec_req,
    output logic              sec_write,
    output logic [ADDR_W-1:0] sec_addr,
    output logic [BE_W-1:0]   sec_be,
    output logic [DATA_W-1:0] sec_wdata,
    input  logic              sec_ack,
    input  logic [DATA_W-1:0] sec_rdata
);
    import dly_txn_pkg::*;

    slot_state_e      state_q, state_d;
    logic             elig;
    logic             hit;
    logic             take_new;
    logic             deliver;
    logic             expired;
    logic             cap;
    logic [3:0]       q_cmd;
    logic [DATA_W-1:0] q_result;

    assign elig     = addr_valid && cmd_eligible(cmd);
    assign take_new = elig && (state_q == S_IDLE);
    assign deliver  = elig && hit && (state_q == S_READY);
    assign cap      = (state_q == S_ISSUE) && sec_ack;

    dly_txn_slot #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) slot_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_new),
        .in_cmd   (cmd),
        .in_addr  (addr),
        .in_be    (be),
        .in_wdata (wdata),
        .cap      (cap),
        .cap_data (sec_rdata),
        .q_cmd    (q_cmd),
        .q_addr   (sec_addr),
        .q_be     (sec_be),
        .q_wdata  (sec_wdata),
        .q_result (q_result),
        .match    (hit)
    );

    dly_txn_discard_tmr #(
        .LIMIT (DISCARD_CYCLES)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == S_READY),
        .expired (expired)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (take_new) state_d = S_ISSUE;
            S_ISSUE: if (sec_ack)  state_d = S_READY;
            S_READY: if (deliver || expired) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // First-data-phase answer, one cycle after the address phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            devsel <= 1'b0;
            stop   <= 1'b0;
            trdy   <= 1'b0;
            rdata  <= '0;
        end else begin
            devsel <= elig;
            stop   <= elig;
            trdy   <= deliver;
            rdata  <= deliver ? q_result : '0;
        end
    end

    assign sec_req   = (state_q == S_ISSUE);
    assign sec_write = cmd_is_write(q_cmd);

endmodule

// File: rtl/dly_txn_target_chk.sv
module dly_txn_target_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_valid,
    input logic [3:0]        cmd,
    input logic              devsel,
    input logic              trdy,
    input logic              stop,
    input logic              sec_req,
    input logic              sec_ack,
    input logic [ADDR_W-1:0] sec_addr
);
    import dly_txn_pkg::*;

    p_ignored_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !cmd_eligible(cmd)) |=> (!devsel && !stop));

    p_retry_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !trdy) |-> devsel);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_req && !sec_ack) |=> (sec_req && $stable(sec_addr)));

    p_complete_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trdy |-> (devsel && stop));

    p_answer_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        devsel |-> $past(addr_valid));

endmodule

bind dly_txn_target dly_txn_target_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_valid (addr_valid),
    .cmd        (cmd),
    .devsel     (devsel),
    .trdy       (trdy),
    .stop       (stop),
    .sec_req    (sec_req),
    .sec_ack    (sec_ack),
    .sec_addr   (sec_addr)
);

// File: tb/dly_txn_target_tb_top.sv
module dly_txn_target_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BW = 4;
    localparam int TMO = 32768;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_valid = 1'b0;
    logic [3:0]    cmd = '0;
    logic [AW-1:0] addr = '0;
    logic [BW-1:0] be = '0;
    logic [DW-1:0] wdata = '0;
    logic          devsel, trdy, stop, sec_req, sec_write;
    logic [DW-1:0] rdata, sec_wdata;
    logic [AW-1:0] sec_addr;
    logic [BW-1:0] sec_be;
    logic          sec_ack = 1'b0;
    logic [DW-1:0] sec_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;
    int ack_delay = 3;
    int wait_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dly_txn_target #(.ADDR_W(AW), .DATA_W(DW), .BE_W(BW), .DISCARD_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .cmd(cmd), .addr(addr),
        .be(be), .wdata(wdata), .devsel(devsel), .trdy(trdy), .stop(stop),
        .rdata(rdata), .sec_req(sec_req), .sec_write(sec_write), .sec_addr(sec_addr),
        .sec_be(sec_be), .sec_wdata(sec_wdata), .sec_ack(sec_ack), .sec_rdata(sec_rdata)
    );

    function automatic logic [DW-1:0] model_data(input logic [AW-1:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    function automatic bit model_elig(input logic [3:0] c);
        return c inside {4'h0, 4'h2, 4'h3, 4'h6, 4'hA, 4'hB, 4'hC, 4'hE};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Slow-side responder
    initial begin
        forever begin
            @(negedge clk);
            if (sec_ack) begin
                sec_ack = 1'b0;
                wait_cnt = 0;
            end else if (sec_req) begin
                if (wait_cnt >= ack_delay) begin
                    sec_ack = 1'b1;
                    sec_rdata = model_data(sec_addr);
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // One address phase; returns answer seen in the following cycle
    task automatic access(input logic [3:0] c, input logic [AW-1:0] a, input logic [BW-1:0] b,
                          input logic [DW-1:0] w, output logic [2:0] dts, output logic [DW-1:0] rd);
        @(negedge clk);
        addr_valid = 1'b1; cmd = c; addr = a; be = b; wdata = w;
        @(negedge clk);
        addr_valid = 1'b0;
        dts = {devsel, trdy, stop};
        rd = rdata;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200 && !(sec_req === 1'b0); i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [2:0] dts;
        logic [DW-1:0] rd;
        logic [AW-1:0] a;
        idle_cycles(3);
        chk("R1 answer at reset", {29'd0, devsel, trdy, stop}, 32'd0);
        chk("R1 sec_req at reset", {31'd0, sec_req}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        idle_cycles(2);

        // Sweep all command codes
        for (int c = 0; c < 16; c++) begin
            a = 32'h1000_0000 + (c << 4);
            access(4'(c), a, 4'hF, 32'hC0DE_0000 + c, dts, rd);
            if (model_elig(4'(c))) begin
                chk("R3 retry shape", {29'd0, dts}, 32'b101);
                chk("R3 sec_req raised", {31'd0, sec_req}, 32'd1);
                chk("R3 sec_addr", sec_addr, a);
                chk("R4 sec_write", {31'd0, sec_write}, {31'd0, (c == 3 || c == 11)});
                wait_ready();
                access(4'(c), a, 4'hF, 32'hC0DE_0000 + c, dts, rd);
                chk("R7 completion shape", {29'd0, dts}, 32'b111);
                chk("R7 rdata", rd, (c == 3 || c == 11) ? 32'd0 : model_data(a));
                @(negedge clk);
                chk("R10 answer one cycle", {29'd0, devsel, trdy, stop}, 32'd0);
            end else begin
                chk("R2 ignored code answer", {29'd0, dts}, 32'd0);
                @(negedge clk);
                chk("R2 ignored code no access", {31'd0, sec_req}, 32'd0);
            end
        end

        // Busy slot: pending repeats and foreign requests
        ack_delay = 20;
        a = 32'h2000_0040;
        access(4'h6, a, 4'h3, 32'd0, dts, rd);
        chk("R3 retry first", {29'd0, dts}, 32'b101);
        access(4'h6, a, 4'h3, 32'd0, dts, rd);
        chk("R6 pending repeat retried", {29'd0, dts}, 32'b101);
        chk("R6 access continues", {31'd0, sec_req}, 32'd1);
        access(4'h6, 32'h2000_0080, 4'h3, 32'd0, dts, rd);
        chk("R5 foreign retried while issuing", {29'd0, dts}, 32'b101);
        chk("R5 stored address kept", sec_addr, a);
        chk("R5 stored be kept", {28'd0, sec_be}, 32'h3);
        wait_ready();
        access(4'h6, a, 4'h1, 32'd0, dts, rd);
        chk("R8 be mismatch retried", {29'd0, dts}, 32'b101);
        access(4'hE, a, 4'h3, 32'd0, dts, rd);
        chk("R8 cmd mismatch retried", {29'd0, dts}, 32'b101);
        access(4'h6, a + 4, 4'h3, 32'd0, dts, rd);
        chk("R5 foreign retried while ready", {29'd0, dts}, 32'b101);
        chk("R5 no new access", {31'd0, sec_req}, 32'd0);
        access(4'h6, a, 4'h3, 32'd0, dts, rd);
        chk("R7 original completes", {29'd0, dts}, 32'b111);
        chk("R7 original data", rd, model_data(a));

        // Write data must match
        ack_delay = 2;
        a = 32'h3000_0100;
        access(4'h3, a, 4'hF, 32'hDEAD_BEEF, dts, rd);
        chk("R4 write data forwarded", sec_wdata, 32'hDEAD_BEEF);
        wait_ready();
        access(4'h3, a, 4'hF, 32'hDEAD_BEEE, dts, rd);
        chk("R8 wdata mismatch retried", {29'd0, dts}, 32'b101);
        access(4'h3, a, 4'hF, 32'hDEAD_BEEF, dts, rd);
        chk("R8 wdata match completes", {29'd0, dts}, 32'b111);

        // Collection just inside the discard window
        a = 32'h4000_0200;
        access(4'h2, a, 4'hF, 32'd0, dts, rd);
        wait_ready();
        idle_cycles(TMO - 6);
        access(4'h2, a, 4'hF, 32'd0, dts, rd);
        chk("R9 inside window completes", {29'd0, dts}, 32'b111);
        chk("R9 inside window data", rd, model_data(a));

        // Collection after the discard window
        a = 32'h4000_0300;
        access(4'h2, a, 4'hF, 32'd0, dts, rd);
        wait_ready();
        idle_cycles(TMO + 4);
        access(4'h2, a, 4'hF, 32'd0, dts, rd);
        chk("R9 discarded result retried", {29'd0, dts}, 32'b101);
        chk("R9 fresh access started", {31'd0, sec_req}, 32'd1);
        wait_ready();
        access(4'h2, a, 4'hF, 32'd0, dts, rd);
        chk("R9 fresh access completes", {29'd0, dts}, 32'b111);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule